// File: doc/BRIEF.md
# Legacy I/O Snoop and DMA/Interrupt Gating

This block sits beside an ISA-style I/O bus and watches its cycles without ever claiming, terminating or answering them. It keeps a private copy of one bit of the floppy controller's digital output register, the DMA-enable bit. That copy is taken from bus writes to either of the two floppy controller base addresses. The bit decides whether the floppy DMA acknowledge (active low) may turn on the utility-bus transceiver output enable (also active low).

The block also latches two interrupt requests toward the host: the keyboard request and the mouse request. Each latch is set by a rising edge on its input and stays set until software reads the keyboard data port. A data-port read always releases the keyboard latch. It releases the mouse latch only while mouse mode is enabled. Mouse mode also decides whether mouse edges are latched at all.

Top module: `legacy_io_snoop`

## Requirements
- R1: While reset is asserted and after it is released with idle inputs, `irq_kbd` and `irq_mouse` are 0 and `ubus_oe_n` is 1 (DMA-enable cleared).
- R2: A write strobe with address 0x3F2 loads the DMA-enable copy from data bit 3 on the next clock. Data bits 7:4 and 2:0 have no effect.
- R3: A write strobe with address 0x372 loads the DMA-enable copy from data bit 3 in the same way as R2.
- R4: Reads of 0x3F2 or 0x372, and writes to any other address, leave the DMA-enable copy unchanged.
- R5: While DMA-enable is 1, `ubus_oe_n` equals `dack_n` combinationally, with no added clock of delay.
- R6: While DMA-enable is 0, `ubus_oe_n` stays 1 whatever `dack_n` does. `ubus_oe_n` is 1 whenever `dack_n` is 1.
- R7: A rising edge on `kbd_irq_in` sets `irq_kbd` on the next clock. `irq_kbd` stays set after the input falls.
- R8: A read strobe with address 0x60 clears `irq_kbd` on the next clock whatever `mouse_en` is. Writes to 0x60 do not clear it.
- R9: A rising edge on `mouse_irq_in` sets `irq_mouse` on the next clock only when `mouse_en` is 1. With `mouse_en` at 0 the edge is ignored.
- R10: A read of 0x60 clears `irq_mouse` only when `mouse_en` is 1. With `mouse_en` at 0 the read leaves `irq_mouse` unchanged.
- R11: A rising edge that arrives in the same cycle as a releasing read of 0x60 wins: the latch is set after that clock.
- R12: An interrupt input held high after a release does not set its latch again until it falls and rises once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | I/O address of the current bus cycle |
| io_rd | input | 1 | Read strobe, active high, sampled on the clock |
| io_wr | input | 1 | Write strobe, active high, sampled on the clock |
| io_data | input | 8 | Write data byte on the bus |
| dack_n | input | 1 | Floppy DMA acknowledge, active low |
| ubus_oe_n | output | 1 | Utility-bus transceiver output enable, active low |
| kbd_irq_in | input | 1 | Keyboard interrupt request from the keyboard controller |
| mouse_irq_in | input | 1 | Mouse interrupt request input |
| mouse_en | input | 1 | Mouse mode configuration bit |
| irq_kbd | output | 1 | Latched keyboard interrupt toward the host |
| irq_mouse | output | 1 | Latched mouse interrupt toward the host |

## Verification
The bench attacks the places where decoding or priority usually slips. It writes data 0xF7 and 0x08 so that a design taking the wrong data bit flips the enable. It sends reads to the floppy addresses and writes to neighbouring addresses, which a loose decoder would accept as updates. It toggles `dack_n` in mid-cycle and checks the output straight away, so a registered gate would lag by one clock. It fires an interrupt edge in the same cycle as the data-port read, where a release-first latch would drop the request. It also holds an input high through a release, where a level-sensitive latch would set again at once. Finally, it flips `mouse_en` around mouse edges and data-port reads, where a design that ignores the mode would set or clear the mouse latch when it should not.

// File: rtl/legacy_snoop_pkg.sv
package legacy_snoop_pkg;

  // Decoded snoop events for the cycle currently on the bus.
  typedef struct packed {
    logic dor_wr;   // write to either floppy output register address
    logic kbd_rd;   // read of the keyboard data port
  } snoop_hit_t;

  localparam int unsigned IRQ_CH  = 2;
  localparam int unsigned CH_KBD  = 0;
  localparam int unsigned CH_MOUS = 1;

endpackage

// File: rtl/snoop_rst_sync.sv
module snoop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/snoop_decode.sv
module snoop_decode
  import legacy_snoop_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] DOR_ADDR_A = 16'h03F2,
  parameter logic [ADDR_W-1:0] DOR_ADDR_B = 16'h0372,
  parameter logic [ADDR_W-1:0] KBD_ADDR   = 16'h0060
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output snoop_hit_t        hit
);

  localparam int unsigned N_DOR = 2;
  localparam logic [N_DOR*ADDR_W-1:0] DOR_LIST = {DOR_ADDR_B, DOR_ADDR_A};

  logic [N_DOR-1:0] dor_match;

  for (genvar g = 0; g < N_DOR; g++) begin : g_dor
    assign dor_match[g] = (addr == DOR_LIST[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    hit        = '0;
    hit.dor_wr = wr & (|dor_match);
    hit.kbd_rd = rd & (addr == KBD_ADDR);
  end

endmodule

// File: rtl/dor_shadow.sv
module dor_shadow #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] data,
  input  logic              dack_n,
  output logic              ubus_oe_n
);

  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << EN_BIT);

  logic dma_en_q;
  logic dma_en_d;
  logic load_en;
  logic unused_bits;

  assign load_en     = wr_hit;
  assign unused_bits = ^(data & KEEP_MASK);

  always_comb begin
    dma_en_d = dma_en_q;
    if (load_en) dma_en_d = data[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_en_q <= 1'b0;
    else        dma_en_q <= dma_en_d;
  end

  // Gate is combinational so the enable tracks the acknowledge in-cycle.
  assign ubus_oe_n = ~(dma_en_q & ~dack_n);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (dma_en_q == $past(data[EN_BIT])));

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(dma_en_q));

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic set_en,
  input  logic rel,
  output logic irq_out
);

  logic prev_q;
  logic hold_q;
  logic hold_d;
  logic rise;

  assign rise = irq_in & ~prev_q & set_en;

  always_comb begin
    hold_d = hold_q;
    if (rise)     hold_d = 1'b1;   // a new edge outranks the release
    else if (rel) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      prev_q <= irq_in;
      hold_q <= hold_d;
    end
  end

  assign irq_out = hold_q;

  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && !prev_q && set_en) |=> irq_out);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !(irq_in && !prev_q && set_en)) |=> !irq_out);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !rel) |=> irq_out);

  assert_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && (prev_q || !set_en)) |=> !irq_out || $past(irq_in && !prev_q && set_en));

endmodule

// File: rtl/legacy_io_snoop.sv
module legacy_io_snoop
  import legacy_snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_data,
  input  logic              dack_n,
  output logic              ubus_oe_n,
  input  logic              kbd_irq_in,
  input  logic              mouse_irq_in,
  input  logic              mouse_en,
  output logic              irq_kbd,
  output logic              irq_mouse
);

  logic              rst_n_i;
  snoop_hit_t        hit;
  logic [IRQ_CH-1:0] ch_in;
  logic [IRQ_CH-1:0] ch_set_en;
  logic [IRQ_CH-1:0] ch_rel;
  logic [IRQ_CH-1:0] ch_out;

  snoop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  snoop_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (io_addr),
    .rd   (io_rd),
    .wr   (io_wr),
    .hit  (hit)
  );

  dor_shadow #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_dor (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_hit    (hit.dor_wr),
    .data      (io_data),
    .dack_n    (dack_n),
    .ubus_oe_n (ubus_oe_n)
  );

  assign ch_in[CH_KBD]  = kbd_irq_in;
  assign ch_in[CH_MOUS] = mouse_irq_in;

  for (genvar c = 0; c < IRQ_CH; c++) begin : g_irq
    if (c == CH_MOUS) begin : g_mode
      assign ch_set_en[c] = mouse_en;
      assign ch_rel[c]    = hit.kbd_rd & mouse_en;
    end else begin : g_always
      assign ch_set_en[c] = 1'b1;
      assign ch_rel[c]    = hit.kbd_rd;
    end
    irq_edge_latch u_lat (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .irq_in  (ch_in[c]),
      .set_en  (ch_set_en[c]),
      .rel     (ch_rel[c]),
      .irq_out (ch_out[c])
    );
  end

  assign irq_kbd   = ch_out[CH_KBD];
  assign irq_mouse = ch_out[CH_MOUS];

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    dack_n |-> ubus_oe_n);

  assert_mouse_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!mouse_en && irq_mouse) |=> irq_mouse);

  assert_mouse_off_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!mouse_en && !irq_mouse) |=> !irq_mouse);

endmodule

// File: tb/legacy_io_snoop_bench.sv
module legacy_io_snoop_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_data;
  logic        dack_n, ubus_oe_n;
  logic        kbd_irq_in, mouse_irq_in, mouse_en;
  logic        irq_kbd, irq_mouse;

  legacy_io_snoop u_legacy_io_snoop (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_data(io_data), .dack_n(dack_n), .ubus_oe_n(ubus_oe_n),
    .kbd_irq_in(kbd_irq_in), .mouse_irq_in(mouse_irq_in), .mouse_en(mouse_en),
    .irq_kbd(irq_kbd), .irq_mouse(irq_mouse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    logic  k;
    logic  m;
    logic  oe;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // stimulus settings applied at the next tick
  logic [15:0] s_addr = 16'h0000;
  logic        s_rd = 0, s_wr = 0, s_dack = 1, s_kin = 0, s_min = 0, s_men = 0;
  logic [7:0]  s_data = 8'h00;

  // reference model state
  logic m_dma = 0, m_k = 0, m_m = 0, pk = 0, pm = 0;

  task automatic tick(input string tag);
    logic wr_hit, rd60, rk, rm, oe_now;
    #5;
    io_addr = s_addr; io_rd = s_rd; io_wr = s_wr; io_data = s_data;
    dack_n = s_dack; kbd_irq_in = s_kin; mouse_irq_in = s_min; mouse_en = s_men;
    #1;
    oe_now = !(m_dma && !s_dack);
    checks++;
    if (ubus_oe_n !== oe_now) begin
      errors++;
      $display("FAIL R5/R6 %s in-cycle oe got %b exp %b", tag, ubus_oe_n, oe_now);
    end
    wr_hit = s_wr && (s_addr == 16'h03F2 || s_addr == 16'h0372);
    rd60   = s_rd && (s_addr == 16'h0060);
    rk     = s_kin && !pk;
    rm     = s_min && !pm && s_men;
    if (wr_hit) m_dma = s_data[3];
    if (rk) m_k = 1; else if (rd60) m_k = 0;
    if (rm) m_m = 1; else if (rd60 && s_men) m_m = 0;
    pk = s_kin; pm = s_min;
    @(posedge clk);
    sb_q.push_back('{k: m_k, m: m_m, oe: !(m_dma && !s_dack), tag: tag});
  endtask

  // monitor: compare one expected item per cycle, half a period after the edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (irq_kbd !== e.k || irq_mouse !== e.m || ubus_oe_n !== e.oe) begin
        errors++;
        $display("FAIL %s got k=%b m=%b oe=%b exp k=%b m=%b oe=%b",
                 e.tag, irq_kbd, irq_mouse, ubus_oe_n, e.k, e.m, e.oe);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; io_addr = 0; io_rd = 0; io_wr = 0; io_data = 0;
    dack_n = 1; kbd_irq_in = 0; mouse_irq_in = 0; mouse_en = 0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (irq_kbd !== 0 || irq_mouse !== 0 || ubus_oe_n !== 1) begin
      errors++;
      $display("FAIL R1 in reset got k=%b m=%b oe=%b exp 0 0 1", irq_kbd, irq_mouse, ubus_oe_n);
    end
    @(posedge clk); #5; rst_n = 1;
    @(posedge clk);
    for (int i = 0; i < 3; i++) tick("R1 idle after reset");

    s_dack = 0; tick("R6 dack with enable clear");
    s_dack = 1; tick("R6 dack release");

    s_addr = 16'h03F2; s_wr = 1; s_data = 8'hF7; tick("R2 other bits ignored");
    s_wr = 0; s_dack = 0; tick("R2 still disabled");
    s_dack = 1; s_wr = 1; s_data = 8'h08; tick("R2 load enable");
    s_wr = 0; s_dack = 0; tick("R5 gate follows dack low");
    s_dack = 1; tick("R5 gate follows dack high");
    s_dack = 0; tick("R5 dack low again");

    s_rd = 1; s_data = 8'h00; tick("R4 read of 3F2 ignored");
    s_rd = 0; s_addr = 16'h03F0; s_wr = 1; tick("R4 write to 3F0 ignored");
    s_addr = 16'h0373; tick("R4 write to 373 ignored");
    s_wr = 0; tick("R4 enable kept");

    s_addr = 16'h0372; s_wr = 1; s_data = 8'hFF & ~8'h08; tick("R3 clear via 372");
    s_wr = 0; tick("R3 disabled");
    s_wr = 1; s_data = 8'h08; tick("R3 set via 372");
    s_wr = 0; tick("R3 enabled");
    s_dack = 1; s_addr = 16'h0000; tick("R3 idle");

    s_kin = 1; tick("R7 kbd edge");
    s_kin = 0; tick("R7 sticky after drop");
    s_addr = 16'h0060; s_wr = 1; tick("R8 write to 60 no clear");
    s_wr = 0; s_rd = 1; s_men = 0; tick("R8 read 60 clears kbd");
    s_rd = 0; tick("R8 idle");

    s_min = 1; tick("R9 mouse edge with mode off");
    s_min = 0; tick("R9 idle");
    s_men = 1; s_min = 1; tick("R9 mouse edge with mode on");
    s_min = 0; tick("R9 sticky");
    s_men = 0; s_rd = 1; tick("R10 read with mode off keeps mouse");
    s_rd = 0; tick("R10 idle");
    s_men = 1; s_rd = 1; tick("R10 read with mode on clears mouse");
    s_rd = 0; tick("R10 idle");

    s_kin = 1; s_min = 1; s_rd = 1; tick("R11 edge beats release");
    s_rd = 0; tick("R11 still set");
    s_rd = 1; tick("R12 release with input high");
    s_rd = 0; tick("R12 level does not reset latch");
    tick("R12 level hold");
    s_kin = 0; s_min = 0; tick("R12 drop");
    s_kin = 1; tick("R12 new edge sets again");
    s_kin = 0; s_addr = 16'h0000; tick("final idle");

    @(negedge clk); @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d exp 0", sb_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule